// File: doc/BRIEF.md
# Processor Status and Control Flags Unit

This block holds the 16-bit flags word of a 16-bit processor core. When the datapath finishes an arithmetic or logical operation, it presents the operands, the result, an operation class and a byte/word width select. On the next clock edge the block updates six status flags: carry, parity, auxiliary carry, zero, sign and overflow. The ALU lives outside the block. Only the result and the operands come in.

Three control flags can be set or cleared one at a time with a small command port. The interrupt-enable flag gates an external interrupt request. The trap flag raises a single-step request after each completed instruction. The direction flag goes out to the string-address stepper, where clear means increment and set means decrement. A whole-word load can replace all defined bits at once, for example when flags are restored from a stack. Undefined bit positions always read as zero.

Top module: `flags_unit`

## Requirements
- R1: After a synchronous active-high reset, `flags_out` is 0x0000 and both `irq_out` and `trap_req` are 0.
- R2: On an ALU update the carry flag (bit 0) behaves by operation class. For add (class 0) it is the unsigned carry out of the operand width. For subtract (class 1) it is set when operand a is below operand b, unsigned. For logic (classes 2 and 3) it is cleared.
- R3: On an ALU update the overflow flag (bit 11) shows signed overflow. For add it is set when both operands have the same sign and the result sign differs. For subtract it is set when the operand signs differ and the result sign differs from operand a. For logic it is cleared.
- R4: On an ALU update the zero flag (bit 6) is set when the result is zero across the operand width. The sign flag (bit 7) copies the result's top bit, which is bit 7 in byte mode (`alu_byte`=1) and bit 15 in word mode.
- R5: On an ALU update the parity flag (bit 2) is set when the low 8 bits of the result hold an even number of ones.
- R6: On an ALU update the auxiliary-carry flag (bit 4) is the carry (add) or borrow (subtract) between bit 3 and bit 4. It is cleared for logic operations.
- R7: A control command sets (`ctl_op`=2) or clears (`ctl_op`=1) a single control flag, and any other `ctl_op` value has no effect. The flag is chosen by `ctl_sel`: 0 selects direction (bit 10), 1 selects interrupt-enable (bit 9), 2 selects trap (bit 8), and 3 selects nothing.
- R8: Bits 1, 3, 5 and 12 to 15 always read as zero. A whole-word load stores `load_word` AND 0x0FD5.
- R9: `irq_out` equals `irq_in` while the interrupt-enable flag is set, and is 0 while it is clear.
- R10: `trap_req` is 1 in the cycle after a cycle in which `insn_done` was 1 with the trap flag set. Otherwise it is 0.
- R11: `dir_dec` always equals the direction flag.
- R12: A whole-word load takes priority over an ALU update and a control command that arrive in the same cycle.
- R13: The status flags do not change in a cycle with no ALU update and no load, and a control command does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_valid | input | 1 | Update status flags from the ALU inputs this cycle |
| alu_class | input | 2 | 0 add, 1 subtract, 2/3 logic |
| alu_byte | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| alu_a | input | 16 | First operand |
| alu_b | input | 16 | Second operand |
| alu_res | input | 16 | ALU result |
| ctl_op | input | 2 | 1 clear, 2 set, else no action |
| ctl_sel | input | 2 | 0 direction, 1 interrupt-enable, 2 trap, 3 none |
| load_valid | input | 1 | Load the whole flags word |
| load_word | input | 16 | Word to load (defined bits only) |
| insn_done | input | 1 | An instruction completed this cycle |
| irq_in | input | 1 | Incoming interrupt request |
| flags_out | output | 16 | Current flags word |
| dir_dec | output | 1 | Direction flag for string stepping |
| irq_out | output | 1 | Gated interrupt request |
| trap_req | output | 1 | Single-step trap request |

## Verification
The embedded assertions check the cycle-level rules on every cycle: reserved bits stay zero, interrupt gating holds, a trap request follows only a completed instruction with the trap flag set, a load stores exactly the masked word, logic operations clear carry and overflow, and the status bits hold when neither an update nor a load occurs. The arithmetic value of each status flag over the full range of operands can only be shown by the bench. It sweeps byte operands densely, word operands at a stride, all three operation classes, and computes the carry, overflow, parity and auxiliary carry with integer arithmetic. The bench also covers command encodings, reset values and priority when several requests collide.

// File: rtl/flags_pkg.sv
package flags_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    localparam int POS_CF = 0;
    localparam int POS_PF = 2;
    localparam int POS_AF = 4;
    localparam int POS_ZF = 6;
    localparam int POS_SF = 7;
    localparam int POS_TF = 8;
    localparam int POS_IF = 9;
    localparam int POS_DF = 10;
    localparam int POS_OF = 11;

    localparam logic [DATA_W-1:0] STATUS_MASK =
        DATA_W'((1 << POS_CF) | (1 << POS_PF) | (1 << POS_AF) |
                (1 << POS_ZF) | (1 << POS_SF) | (1 << POS_OF));
    localparam logic [DATA_W-1:0] CONTROL_MASK =
        DATA_W'((1 << POS_TF) | (1 << POS_IF) | (1 << POS_DF));
    localparam logic [DATA_W-1:0] DEFINED_MASK = STATUS_MASK | CONTROL_MASK;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'd0,
        CLS_SUB   = 2'd1,
        CLS_LOGIC = 2'd2,
        CLS_LOG2  = 2'd3
    } alu_class_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_CLR  = 2'd1,
        CMD_SET  = 2'd2,
        CMD_RSV  = 2'd3
    } ctl_cmd_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } status_t;

    typedef struct packed {
        logic df;
        logic ief;
        logic tf;
    } control_t;

    function automatic logic even_parity(input logic [BYTE_W-1:0] v);
        return ~(^v);
    endfunction

    function automatic logic [DATA_W-1:0] pack_word(input status_t s, input control_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[POS_CF] = s.cf;
        w[POS_PF] = s.pf;
        w[POS_AF] = s.af;
        w[POS_ZF] = s.zf;
        w[POS_SF] = s.sf;
        w[POS_OF] = s.of;
        w[POS_TF] = c.tf;
        w[POS_IF] = c.ief;
        w[POS_DF] = c.df;
        return w;
    endfunction

    function automatic status_t unpack_status(input logic [DATA_W-1:0] w);
        status_t s;
        s.cf = w[POS_CF];
        s.pf = w[POS_PF];
        s.af = w[POS_AF];
        s.zf = w[POS_ZF];
        s.sf = w[POS_SF];
        s.of = w[POS_OF];
        return s;
    endfunction

    function automatic control_t unpack_control(input logic [DATA_W-1:0] w);
        control_t c;
        c.tf  = w[POS_TF];
        c.ief = w[POS_IF];
        c.df  = w[POS_DF];
        return c;
    endfunction
endpackage

// File: rtl/flags_status_calc.sv
module flags_status_calc
    import flags_pkg::*;
(
    input  alu_class_e          op_class,
    input  logic                byte_mode,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic [DATA_W-1:0]   res,
    output status_t             status
);
    logic a_top, b_top, r_top;
    logic carry_add, borrow_sub, res_zero, nib_cross, signed_ovf;
    logic [DATA_W-1:0] xor_all;

    always_comb begin
        a_top = byte_mode ? opa[BYTE_W-1] : opa[DATA_W-1];
        b_top = byte_mode ? opb[BYTE_W-1] : opb[DATA_W-1];
        r_top = byte_mode ? res[BYTE_W-1] : res[DATA_W-1];

        carry_add  = byte_mode ? (res[BYTE_W-1:0] < opa[BYTE_W-1:0]) : (res < opa);
        borrow_sub = byte_mode ? (opa[BYTE_W-1:0] < opb[BYTE_W-1:0]) : (opa < opb);
        res_zero   = byte_mode ? (res[BYTE_W-1:0] == '0) : (res == '0);

        xor_all   = opa ^ opb ^ res;
        nib_cross = xor_all[NIB_W];

        signed_ovf = 1'b0;
        status     = '0;
        unique case (op_class)
            CLS_ADD: begin
                signed_ovf = (a_top == b_top) && (r_top != a_top);
                status.cf  = carry_add;
                status.af  = nib_cross;
            end
            CLS_SUB: begin
                signed_ovf = (a_top != b_top) && (r_top != a_top);
                status.cf  = borrow_sub;
                status.af  = nib_cross;
            end
            default: begin
                status.cf = 1'b0;
                status.af = 1'b0;
            end
        endcase
        status.of = signed_ovf;
        status.zf = res_zero;
        status.sf = r_top;
        status.pf = even_parity(res[BYTE_W-1:0]);
    end
endmodule

// File: rtl/flags_control_calc.sv
module flags_control_calc
    import flags_pkg::*;
(
    input  control_t    cur,
    input  ctl_cmd_e    cmd,
    input  logic [1:0]  sel,
    output control_t    nxt
);
    logic act, val;

    always_comb begin
        act = (cmd == CMD_SET) || (cmd == CMD_CLR);
        val = (cmd == CMD_SET);
        nxt = cur;
        if (act) begin
            unique case (sel)
                2'd0:    nxt.df  = val;
                2'd1:    nxt.ief = val;
                2'd2:    nxt.tf  = val;
                default: nxt     = cur;
            endcase
        end
    end
endmodule

// File: rtl/flags_unit.sv
module flags_unit
    import flags_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                alu_valid,
    input  logic [1:0]          alu_class,
    input  logic                alu_byte,
    input  logic [DATA_W-1:0]   alu_a,
    input  logic [DATA_W-1:0]   alu_b,
    input  logic [DATA_W-1:0]   alu_res,
    input  logic [1:0]          ctl_op,
    input  logic [1:0]          ctl_sel,
    input  logic                load_valid,
    input  logic [DATA_W-1:0]   load_word,
    input  logic                insn_done,
    input  logic                irq_in,
    output logic [DATA_W-1:0]   flags_out,
    output logic                dir_dec,
    output logic                irq_out,
    output logic                trap_req
);
    status_t  stat_q, stat_calc, stat_d;
    control_t ctrl_q, ctrl_calc, ctrl_d;
    logic     trap_q;

    flags_status_calc u_status (
        .op_class (alu_class_e'(alu_class)),
        .byte_mode(alu_byte),
        .opa      (alu_a),
        .opb      (alu_b),
        .res      (alu_res),
        .status   (stat_calc)
    );

    flags_control_calc u_control (
        .cur(ctrl_q),
        .cmd(ctl_cmd_e'(ctl_op)),
        .sel(ctl_sel),
        .nxt(ctrl_calc)
    );

    always_comb begin
        if (load_valid) begin
            stat_d = unpack_status(load_word);
            ctrl_d = unpack_control(load_word);
        end else begin
            stat_d = alu_valid ? stat_calc : stat_q;
            ctrl_d = ctrl_calc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            ctrl_q <= '0;
            trap_q <= 1'b0;
        end else begin
            stat_q <= stat_d;
            ctrl_q <= ctrl_d;
            trap_q <= insn_done && ctrl_q.tf;
        end
    end

    assign flags_out = pack_word(stat_q, ctrl_q);
    assign dir_dec   = ctrl_q.df;
    assign irq_out   = irq_in && ctrl_q.ief;
    assign trap_req  = trap_q;

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_out & ~DEFINED_MASK) == '0);
    // R12
    load_store_chk: assert property (@(posedge clk) disable iff (rst)
        load_valid |=> flags_out == ($past(load_word) & DEFINED_MASK));
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (flags_out[POS_IF] && irq_in));
    // R10
    trap_origin_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> $past(insn_done && flags_out[POS_TF]));
    // R2
    logic_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && !load_valid && alu_class[1]) |=>
            (!flags_out[POS_CF] && !flags_out[POS_OF]));
    // R13
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!alu_valid && !load_valid) |=> $stable(flags_out & STATUS_MASK));
    // R11
    dir_follow_chk: assert property (@(posedge clk) disable iff (rst)
        dir_dec == flags_out[POS_DF]);
endmodule

// File: tb/flags_unit_tb.sv
module flags_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        alu_valid;
    logic [1:0]  alu_class;
    logic        alu_byte;
    logic [15:0] alu_a, alu_b, alu_res;
    logic [1:0]  ctl_op, ctl_sel;
    logic        load_valid;
    logic [15:0] load_word;
    logic        insn_done, irq_in;
    logic [15:0] flags_out;
    logic        dir_dec, irq_out, trap_req;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic [15:0] exp_w;

    localparam logic [15:0] STAT_M = 16'h08D5;

    always #5 clk = ~clk;

    flags_unit dut_i (
        .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_class(alu_class),
        .alu_byte(alu_byte), .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res),
        .ctl_op(ctl_op), .ctl_sel(ctl_sel), .load_valid(load_valid),
        .load_word(load_word), .insn_done(insn_done), .irq_in(irq_in),
        .flags_out(flags_out), .dir_dec(dir_dec), .irq_out(irq_out),
        .trap_req(trap_req)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        alu_valid = 0; ctl_op = 0; ctl_sel = 3; load_valid = 0;
        insn_done = 0;
    endtask

    function automatic logic [15:0] model_status(input int a, input int b, input int cls,
                                                 input bit bm, output logic [15:0] res);
        int w, m, half, ai, bi, r, sa, sb, sr;
        logic [15:0] s;
        w = bm ? 8 : 16;
        m = (1 << w) - 1;
        half = 1 << (w - 1);
        ai = a & m; bi = b & m;
        if (cls == 0)      r = (ai + bi) & m;
        else if (cls == 1) r = (ai - bi) & m;
        else               r = ai ^ bi;
        res = bm ? {8'h5A, 8'(r)} : 16'(r);
        sa = ai >= half ? ai - 2*half : ai;
        sb = bi >= half ? bi - 2*half : bi;
        s = '0;
        if (cls == 0) begin
            s[0]  = (ai + bi) > m;
            s[4]  = ((ai & 15) + (bi & 15)) > 15;
            sr = sa + sb;
            s[11] = (sr >= half) || (sr < -half);
        end else if (cls == 1) begin
            s[0]  = ai < bi;
            s[4]  = (ai & 15) < (bi & 15);
            sr = sa - sb;
            s[11] = (sr >= half) || (sr < -half);
        end
        s[6] = (r == 0);
        s[7] = (r >= half);
        s[2] = ~(^8'(r));
        return s;
    endfunction

    task automatic run_alu(input int a, input int b, input int cls, input bit bm, input string tag);
        logic [15:0] st, rr;
        st = model_status(a, b, cls, bm, rr);
        alu_a = bm ? {8'hC3, 8'(a)} : 16'(a);
        alu_b = bm ? {8'h3C, 8'(b)} : 16'(b);
        alu_res = rr; alu_class = 2'(cls); alu_byte = bm; alu_valid = 1;
        tick();
        alu_valid = 0;
        exp_w = (exp_w & ~STAT_M) | st;
        chk(tag, flags_out, exp_w);
    endtask

    task automatic ctl(input int op, input int sel);
        ctl_op = 2'(op); ctl_sel = 2'(sel);
        tick();
        ctl_op = 0; ctl_sel = 3;
        if (op == 1 || op == 2) begin
            if (sel == 0) exp_w[10] = (op == 2);
            if (sel == 1) exp_w[9]  = (op == 2);
            if (sel == 2) exp_w[8]  = (op == 2);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        idle();
        alu_class = 0; alu_byte = 0; alu_a = 0; alu_b = 0; alu_res = 0;
        load_word = 0; irq_in = 0; rst = 1;
        @(negedge clk); tick();
        rst = 0;
        exp_w = 16'h0000;
        // R1 reset state
        chk("R1 flags", flags_out, 16'h0000);
        chk("R1 irq/trap", {14'b0, irq_out, trap_req}, 16'h0);

        // R7 / R11 control commands and encodings
        ctl(2, 0); chk("R7 set dir", flags_out, exp_w);
        chk("R11 dir_dec", {15'b0, dir_dec}, 16'h1);
        ctl(2, 1); chk("R7 set ie", flags_out, exp_w);
        ctl(2, 2); chk("R7 set trap", flags_out, exp_w);
        ctl(3, 0); chk("R7 reserved op", flags_out, exp_w);
        ctl(0, 1); chk("R7 none op", flags_out, exp_w);
        ctl(1, 3); chk("R7 sel none", flags_out, exp_w);
        ctl(1, 0); chk("R7 clr dir", flags_out, exp_w);
        chk("R11 dir_dec clr", {15'b0, dir_dec}, 16'h0);
        ctl(1, 2); chk("R7 clr trap", flags_out, exp_w);

        // R2..R6 byte sweep across classes
        for (int a = 0; a < 256; a += 5)
            for (int b = 0; b < 256; b += 9)
                for (int c = 0; c < 3; c++)
                    run_alu(a, b, c, 1'b1, "R2 R3 R4 R5 R6 byte");
        // boundary bytes
        run_alu(8'h7F, 8'h01, 0, 1'b1, "R3 byte pos ovf");
        run_alu(8'h80, 8'h01, 1, 1'b1, "R3 byte neg ovf");
        run_alu(8'hFF, 8'h01, 0, 1'b1, "R2 R4 byte wrap zero");
        run_alu(8'h0F, 8'h01, 0, 1'b1, "R6 nibble carry");
        run_alu(8'h10, 8'h01, 1, 1'b1, "R6 nibble borrow");
        run_alu(8'hFF, 8'hFF, 2, 1'b1, "R2 logic clears");
        run_alu(8'hFF, 8'hFF, 3, 1'b1, "R2 logic class3");
        // word sweep
        for (int a = 0; a < 65536; a += 4099)
            for (int b = 0; b < 65536; b += 3001)
                for (int c = 0; c < 4; c++)
                    run_alu(a, b, c, 1'b0, "R2 R3 R4 R5 R6 word");
        run_alu(16'h7FFF, 16'h0001, 0, 1'b0, "R3 word ovf");
        run_alu(16'hFFFF, 16'h0001, 0, 1'b0, "R2 word carry");
        run_alu(16'h0100, 16'h0001, 1, 1'b0, "R5 word parity low");
        run_alu(16'h8000, 16'h8000, 1, 1'b0, "R4 word zero");

        // R13 status unchanged by control command and idle
        run_alu(16'h0000, 16'h0001, 1, 1'b0, "R13 prep");
        ctl(2, 0); chk("R13 ctl keeps status", flags_out, exp_w);
        tick(); chk("R13 idle keeps status", flags_out, exp_w);

        // R8 load
        load_word = 16'hFFFF; load_valid = 1; tick(); load_valid = 0;
        exp_w = 16'h0FD5; chk("R8 load mask", flags_out, exp_w);
        load_word = 16'hF02A; load_valid = 1; tick(); load_valid = 0;
        exp_w = 16'h0000; chk("R8 undefined ignored", flags_out, exp_w);

        // R12 priority
        load_word = 16'h0A44; load_valid = 1; ctl_op = 2; ctl_sel = 1;
        alu_valid = 1; alu_class = 0; alu_byte = 0; alu_a = 16'hFFFF; alu_b = 1; alu_res = 0;
        tick(); idle();
        exp_w = 16'h0A44; chk("R12 load wins", flags_out, exp_w);

        // R9 interrupt gating
        ctl(1, 1); irq_in = 1; #1;
        chk("R9 gated off", {15'b0, irq_out}, 16'h0);
        ctl(2, 1); #1;
        chk("R9 passed", {15'b0, irq_out}, 16'h1);
        irq_in = 0; #1;
        chk("R9 no request", {15'b0, irq_out}, 16'h0);

        // R10 trap
        ctl(2, 2);
        insn_done = 1; tick(); insn_done = 0;
        chk("R10 trap raised", {15'b0, trap_req}, 16'h1);
        tick(); chk("R10 trap one cycle", {15'b0, trap_req}, 16'h0);
        ctl(1, 2);
        insn_done = 1; tick(); insn_done = 0;
        chk("R10 no trap when clear", {15'b0, trap_req}, 16'h0);
        chk("R7 final word", flags_out, exp_w);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule